// File: doc/BRIEF.md
# QPSK Carrier Modulator

This block turns a serial bit stream into a digital passband sample stream using quadrature phase keying. Bits arrive one per strobe and are grouped in pairs. The first bit of each pair selects the sign of the in-phase channel. The second bit selects the sign of the quadrature channel. Each channel either passes its carrier sample unchanged or negates it, and the two channel products are added to form the output sample.

The cosine and sine carrier samples come from an external oscillator through input ports. A completed pair does not take effect at once. It waits in a pending slot until the cosine input crosses zero on a rising edge, so that symbol changes only happen at that point of the carrier. If a second pair completes while one is still waiting, the newer pair replaces the waiting one and a sticky overrun flag is raised.

Top module: `qpsk_mod`

## Requirements
- R1: After reset, the first accepted bit of each pair (the even bit) sets the in-phase sign and the second (the odd bit) sets the quadrature sign. A bit is accepted on a clock edge where `bit_vld_i` is high. `i_sign_o`/`q_sign_o` show the active signs, where 1 means inverted.
- R2: A sign value of 0 passes the carrier sample unchanged. A sign value of 1 replaces it with its two's-complement negation.
- R3: The in-phase channel uses `cos_i` and the quadrature channel uses `sin_i`.
- R4: `sample_o` is the sum of the two channel products. It is one bit wider than the carriers and never wraps. It is registered, so it reflects the carrier samples present one cycle earlier.
- R5: Negating the most negative carrier value gives the most positive value (+2047 for 12-bit carriers).
- R6: A pending pair is loaded only on a cycle where the previous `cos_i` was negative and the current `cos_i` is zero or positive. That cycle's sample already uses the new signs. `sym_stb_o` is high for exactly the one cycle after such a load, and the signs never change without it.
- R7: If a pair completes while an earlier pair is still pending and not being loaded, the newer pair replaces it and `overrun_o` rises and stays high until reset.
- R8: During and after reset, `sample_o`, both signs, `sym_stb_o` and `overrun_o` are 0.
- R9: With ideal quadrature carriers of amplitude A, each pair (i,q) places the output at the matching constellation point. The output is −A or +A by the in-phase sign where the cosine peaks, and −A or +A by the quadrature sign where the sine peaks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Bit strobe, one bit accepted per high cycle |
| cos_i | input | 12 | Signed cosine carrier sample |
| sin_i | input | 12 | Signed sine carrier sample |
| sample_o | output | 13 | Signed modulated output sample |
| i_sign_o | output | 1 | Active in-phase sign (1 = inverted) |
| q_sign_o | output | 1 | Active quadrature sign (1 = inverted) |
| sym_stb_o | output | 1 | One-cycle strobe when a new symbol is loaded |
| overrun_o | output | 1 | Sticky flag: a pending pair was overwritten |

## Verification
All four pairs 00, 01, 10 and 11 are sent over a free-running ideal 16-sample carrier. Reading the output at the cosine and sine peaks tells whether each channel has the right sign and the right carrier. Held, hand-driven carrier values are then used without a rising crossing, which shows that a waiting pair does not change the signs. Two pairs sent back to back check that the newer pair wins and that overrun sticks. Full-scale negative carriers probe the saturating negation. A reference model checks every cycle, and this also catches any strobe or latency slip.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  typedef struct packed {
    logic i;
    logic q;
  } dibit_t;

  localparam int unsigned NCH = 2;
endpackage

// File: rtl/qpsk_zc.sv
module qpsk_zc #(
  parameter int unsigned CAR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CAR_W-1:0] cos_i,
  output logic             zc_o
);
  logic prev_neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_neg_q <= 1'b0;
    else         prev_neg_q <= cos_i[CAR_W-1];
  end

  // rising crossing: negative before, non-negative now
  assign zc_o = prev_neg_q & ~cos_i[CAR_W-1];
endmodule

// File: rtl/qpsk_dibit_pack.sv
module qpsk_dibit_pack
  import qpsk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_i,
  input  logic   bit_vld_i,
  input  logic   take_i,
  output logic   pend_vld_o,
  output dibit_t pend_o,
  output logic   overrun_o
);
  logic odd_q, even_q, done;

  assign done = bit_vld_i & odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= 1'b0;
      even_q <= 1'b0;
    end else if (bit_vld_i) begin
      odd_q <= ~odd_q;
      if (!odd_q) even_q <= bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_o <= 1'b0;
      pend_o     <= '0;
      overrun_o  <= 1'b0;
    end else if (done) begin
      pend_o     <= '{i: even_q, q: bit_i};
      pend_vld_o <= 1'b1;
      if (pend_vld_o && !take_i) overrun_o <= 1'b1;
    end else if (take_i) begin
      pend_vld_o <= 1'b0;
    end
  end

  p_pend_on_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_vld_o) |-> $past(bit_vld_i && odd_q));
  p_overrun_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/qpsk_chan.sv
module qpsk_chan #(
  parameter int unsigned CAR_W = 12
) (
  input  logic signed [CAR_W-1:0] car_i,
  input  logic                    inv_i,
  output logic signed [CAR_W-1:0] prod_o
);
  localparam logic signed [CAR_W-1:0] MAX_V = {1'b0, {(CAR_W-1){1'b1}}};
  localparam logic signed [CAR_W-1:0] MIN_V = {1'b1, {(CAR_W-1){1'b0}}};

  always_comb begin
    if (!inv_i)              prod_o = car_i;
    else if (car_i == MIN_V) prod_o = MAX_V;
    else                     prod_o = -car_i;
  end

  always_comb begin
    if (inv_i && car_i != '0)
      p_neg_sign_r2: assert (prod_o[CAR_W-1] != car_i[CAR_W-1]);
    if (inv_i && car_i == MIN_V)
      p_sat_r5: assert (prod_o > 0);
  end
endmodule

// File: rtl/qpsk_mod.sv
module qpsk_mod
  import qpsk_pkg::*;
#(
  parameter int unsigned CAR_W = 12,
  localparam int unsigned OUT_W = CAR_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_i,
  input  logic                    bit_vld_i,
  input  logic signed [CAR_W-1:0] cos_i,
  input  logic signed [CAR_W-1:0] sin_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    i_sign_o,
  output logic                    q_sign_o,
  output logic                    sym_stb_o,
  output logic                    overrun_o
);
  logic   zc, take, pend_vld;
  dibit_t pend, sign_q, sign_nxt;

  logic signed [CAR_W-1:0] car  [NCH];
  logic signed [CAR_W-1:0] prod [NCH];
  logic                    inv  [NCH];
  logic signed [OUT_W-1:0] ext  [NCH];

  qpsk_zc #(.CAR_W(CAR_W)) u_zc (
    .clk_i(clk_i), .rst_ni(rst_ni), .cos_i(cos_i), .zc_o(zc)
  );

  assign take = zc & pend_vld;

  qpsk_dibit_pack u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .take_i(take), .pend_vld_o(pend_vld), .pend_o(pend), .overrun_o(overrun_o)
  );

  // new signs already apply to the crossing sample
  assign sign_nxt = take ? pend : sign_q;

  assign car[0] = cos_i;
  assign car[1] = sin_i;
  assign inv[0] = sign_nxt.i;
  assign inv[1] = sign_nxt.q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qpsk_chan #(.CAR_W(CAR_W)) u_chan (
      .car_i(car[c]), .inv_i(inv[c]), .prod_o(prod[c])
    );
    assign ext[c] = {prod[c][CAR_W-1], prod[c]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q    <= '0;
      sym_stb_o <= 1'b0;
      sample_o  <= '0;
    end else begin
      sign_q    <= sign_nxt;
      sym_stb_o <= take;
      sample_o  <= ext[0] + ext[1];
    end
  end

  assign i_sign_o = sign_q.i;
  assign q_sign_o = sign_q.q;

  p_stb_at_zc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_stb_o |-> $past(zc));
  p_stb_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_stb_o |=> !sym_stb_o);
  p_sign_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_o |-> $stable({i_sign_o, q_sign_o}));
endmodule

// File: tb/qpsk_mod_bench.sv
module qpsk_mod_bench;
  localparam int CW  = 12;
  localparam int AMP = 2000;
  localparam int PER = 16;
  localparam int MAXV = (1 << (CW - 1)) - 1;
  localparam int MINV = -(1 << (CW - 1));

  typedef struct {
    int smp; bit is; bit qs; bit stb; bit ovr; bit ideal; int idx;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_v = 1'b0, vld = 1'b0;
  logic signed [CW-1:0] cos_v = '0, sin_v = '0;
  logic signed [CW:0] sample;
  logic i_s, q_s, stb, ovr;

  int checks = 0, errors = 0;
  int idx = 0;
  bit man = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  qpsk_mod u_qpsk_mod (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_v), .bit_vld_i(vld),
    .cos_i(cos_v), .sin_i(sin_v), .sample_o(sample), .i_sign_o(i_s),
    .q_sign_o(q_s), .sym_stb_o(stb), .overrun_o(ovr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int chan(int c, bit inv);
    if (!inv) return c;
    return (c == MINV) ? MAXV : -c;
  endfunction

  // ideal free-running carrier
  always @(negedge clk) if (!man) begin
    idx   <= (idx + 1) % PER;
    cos_v <= CW'(rnd(AMP * $cos(2.0 * 3.14159265358979 * ((idx + 1) % PER) / PER)));
    sin_v <= CW'(rnd(AMP * $sin(2.0 * 3.14159265358979 * ((idx + 1) % PER) / PER)));
  end

  // reference model from the requirements
  bit m_odd, m_even, m_pv, m_pi, m_pq, m_si, m_sq, m_ovr, m_prevneg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_odd, m_even, m_pv, m_pi, m_pq, m_si, m_sq, m_ovr, m_prevneg} = '0;
      q.delete();
    end else begin
      item_t it;
      bit load, c_neg;
      int c, s;
      c = int'(cos_v); s = int'(sin_v);
      c_neg = (c < 0);
      load = m_prevneg && !c_neg && m_pv;
      if (load) begin m_si = m_pi; m_sq = m_pq; end
      it.smp = chan(c, m_si) + chan(s, m_sq);
      it.is = m_si; it.qs = m_sq; it.stb = load;
      it.ideal = !man; it.idx = idx;
      if (vld && m_odd) begin
        if (m_pv && !load) m_ovr = 1'b1;
        m_pi = m_even; m_pq = bit_v; m_pv = 1'b1;
      end else if (load) m_pv = 1'b0;
      if (vld) begin
        if (!m_odd) m_even = bit_v;
        m_odd = !m_odd;
      end
      it.ovr = m_ovr;
      m_prevneg = c_neg;
      q.push_back(it);
    end
  end

  // monitor
  always @(negedge clk) if (rst_n && q.size() > 0) begin
    item_t e;
    e = q.pop_front();
    chk("R4 sample", int'(sample), e.smp);
    chk("R1 i_sign", int'(i_s), int'(e.is));
    chk("R1 q_sign", int'(q_s), int'(e.qs));
    chk("R6 strobe", int'(stb), int'(e.stb));
    chk("R7 overrun", int'(ovr), int'(e.ovr));
    if (e.ideal && e.idx == 0) chk("R9 cos peak", int'(sample), e.is ? -AMP : AMP);
    if (e.ideal && e.idx == PER / 4) chk("R9 sin peak R3", int'(sample), e.qs ? -AMP : AMP);
  end

  task automatic send_bit(bit b);
    bit_v = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic send_pair(bit bi, bit bq);
    send_bit(bi);
    send_bit(bq);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 sample", int'(sample), 0);
    chk("R8 signs", int'({i_s, q_s}), 0);
    chk("R8 strobe", int'(stb), 0);
    chk("R8 overrun", int'(ovr), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    for (int d = 0; d < 4; d++) begin
      send_pair(d[1], d[0]);
      repeat (40) @(negedge clk);
      chk("R1 loaded pair", int'({i_s, q_s}), d);
    end
    // hand-driven carriers: no crossing while cosine stays positive
    man = 1'b1; cos_v = 500; sin_v = 0;
    repeat (3) @(negedge clk);
    send_pair(1'b1, 1'b0);
    send_pair(1'b0, 1'b1);
    chk("R7 overrun set", int'(ovr), 1);
    chk("R6 no load without crossing", int'({i_s, q_s}), 2'b11);
    repeat (4) @(negedge clk);
    chk("R6 still held", int'({i_s, q_s}), 2'b11);
    cos_v = -500; @(negedge clk);
    cos_v = 0;    @(negedge clk);
    chk("R6 strobe at crossing", int'(stb), 1);
    chk("R7 newer pair wins", int'({i_s, q_s}), 2'b01);
    chk("R2 sample new signs", int'(sample), 0);
    @(negedge clk);
    chk("R6 strobe one cycle", int'(stb), 0);
    chk("R7 overrun sticky", int'(ovr), 1);
    cos_v = 700; sin_v = 300; @(negedge clk);
    @(negedge clk);
    chk("R2 R3 i pass q invert", int'(sample), 700 - 300);
    send_pair(1'b1, 1'b1);
    cos_v = -3; @(negedge clk);
    cos_v = 3;  @(negedge clk);
    chk("R6 load 11", int'({i_s, q_s}), 2'b11);
    cos_v = CW'(MINV); sin_v = CW'(MINV); @(negedge clk);
    @(negedge clk);
    chk("R5 saturating negate", int'(sample), 2 * MAXV);
    cos_v = CW'(MAXV); sin_v = CW'(MAXV); @(negedge clk);
    @(negedge clk);
    chk("R4 full-scale sum", int'(sample), -2 * MAXV);
    man = 1'b0;
    repeat (40) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule